// File: doc/BRIEF.md
# Host I/O Strobe Handshake Controller

This controller sits behind the I/O read and I/O write strobes of an ISA-bus peripheral. Both strobes are active low. The controller turns each host access into a fixed sequence on four control lines: data direction, address gate, data gate and bus-drive enable.

A new access first passes through a one-clock settling step. The controller then latches the address and decides whether the cycle is a read or a write. It holds that state until the host lets its strobe go high again.

The strobes arrive from another clock domain, so each one passes through a synchroniser chain inside the block. All four control lines come straight from flip-flops, so decode glitches never reach the pins.

Top module: `isa_strobe_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the controller goes to idle and all four control outputs are low after that edge.
- R2: In idle with both synchronised strobes high, the controller stays in idle and the control code {dir_o, agate_o, dgate_o, drive_o} is 4'b0000.
- R3: In idle, if either synchronised strobe is low, the next state is the settling state, and the settling state drives code 4'b0101.
- R4: The settling state moves to the address-latched state on the next clock whatever the strobes are, and the address-latched state drives code 4'b0101.
- R5: In the address-latched state the next state depends on the synchronised strobes:
  - read low with write high leads to read-active;
  - write low with read high leads to write-active;
  - any other combination leads to idle.
- R6: Read-active stays in place while read is low and write is high, and it drives code 4'b1001.
- R7: Write-active stays in place while write is low and read is high, and it drives code 4'b0011.
- R8: From read-active or write-active, any other strobe combination returns the controller to idle, including release (both high) and both low together. Unused state encodings also fall to idle.
- R9: Each strobe passes through SYNC_STAGES flip-flops (default 2), which reset to the inactive level (high). A strobe change made between edges first affects the state and the outputs at the third rising edge after the change.
- R10: The control code only ever takes one of the values 4'b0000, 4'b0101, 4'b1001 or 4'b0011, and it always matches the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single global clock |
| rst | input | 1 | Synchronous reset, active high |
| ior_n | input | 1 | Host I/O read strobe, active low, asynchronous |
| iow_n | input | 1 | Host I/O write strobe, active low, asynchronous |
| dir_o | output | 1 | Data direction, registered |
| agate_o | output | 1 | Address gate, registered |
| dgate_o | output | 1 | Data gate, registered |
| drive_o | output | 1 | Bus-drive enable, registered |

## Verification
The properties are written against the strobes after the synchroniser, not against the raw pins. They therefore assume that each raw strobe stays stable long enough to pass through the chain as one clean level. The stimulus meets this by changing the strobes only on falling clock edges and holding each level for at least one whole clock. The stimulus still includes one-clock pulses, both strobes low together, and a reset in the middle of an access, so the fall-back-to-idle paths are exercised.

// File: rtl/isa_strobe_pkg.sv
package isa_strobe_pkg;

  localparam int CTL_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ADDR = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } hs_state_t;

  // Control code order: {direction, address gate, data gate, drive enable}
  localparam logic [CTL_W-1:0] CODE_IDLE = 4'b0000;
  localparam logic [CTL_W-1:0] CODE_ADDR = 4'b0101;
  localparam logic [CTL_W-1:0] CODE_RD   = 4'b1001;
  localparam logic [CTL_W-1:0] CODE_WR   = 4'b0011;

  function automatic logic [CTL_W-1:0] ctl_of(input hs_state_t st);
    case (st)
      ST_PRE,
      ST_ADDR: ctl_of = CODE_ADDR;
      ST_RD:   ctl_of = CODE_RD;
      ST_WR:   ctl_of = CODE_WR;
      default: ctl_of = CODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/isa_sync_chain.sv
module isa_sync_chain #(
  parameter int STAGES   = 2,
  parameter bit RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RST_LVL;
    else     chain_q[0] <= d_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[gi] <= RST_LVL;
      else     chain_q[gi] <= chain_q[gi-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/isa_fsm_next.sv
module isa_fsm_next
  import isa_strobe_pkg::*;
(
  input  hs_state_t cur_i,
  input  logic      rd_n_i,
  input  logic      wr_n_i,
  output hs_state_t nxt_o
);
  logic rd_only, wr_only, none_low;

  assign rd_only  = !rd_n_i &&  wr_n_i;
  assign wr_only  =  rd_n_i && !wr_n_i;
  assign none_low =  rd_n_i &&  wr_n_i;

  always_comb begin
    nxt_o = ST_IDLE;
    case (cur_i)
      ST_IDLE: nxt_o = none_low ? ST_IDLE : ST_PRE;
      ST_PRE:  nxt_o = ST_ADDR;
      ST_ADDR: begin
        if (rd_only)      nxt_o = ST_RD;
        else if (wr_only) nxt_o = ST_WR;
        else              nxt_o = ST_IDLE;
      end
      ST_RD:   nxt_o = rd_only ? ST_RD : ST_IDLE;
      ST_WR:   nxt_o = wr_only ? ST_WR : ST_IDLE;
      default: nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/isa_ctl_reg.sv
module isa_ctl_reg
  import isa_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  hs_state_t        nxt_i,
  output hs_state_t        state_o,
  output logic [CTL_W-1:0] ctl_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= ST_IDLE;
      ctl_o   <= CODE_IDLE;
    end else begin
      state_o <= nxt_i;
      ctl_o   <= ctl_of(nxt_i);
    end
  end
endmodule

// File: rtl/isa_strobe_fsm.sv
module isa_strobe_fsm
  import isa_strobe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ior_n,
  input  logic iow_n,
  output logic dir_o,
  output logic agate_o,
  output logic dgate_o,
  output logic drive_o
);
  logic             rd_n_s, wr_n_s;
  hs_state_t        state_q, state_d;
  logic [CTL_W-1:0] ctl_q;

  isa_sync_chain #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync_rd (
    .clk(clk), .rst(rst), .d_i(ior_n), .q_o(rd_n_s)
  );

  isa_sync_chain #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync_wr (
    .clk(clk), .rst(rst), .d_i(iow_n), .q_o(wr_n_s)
  );

  isa_fsm_next u_next (
    .cur_i(state_q), .rd_n_i(rd_n_s), .wr_n_i(wr_n_s), .nxt_o(state_d)
  );

  isa_ctl_reg u_reg (
    .clk(clk), .rst(rst), .nxt_i(state_d), .state_o(state_q), .ctl_o(ctl_q)
  );

  assign {dir_o, agate_o, dgate_o, drive_o} = ctl_q;
endmodule

// File: rtl/isa_strobe_fsm_chk.sv
module isa_strobe_fsm_chk
  import isa_strobe_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rd_n_s,
  input logic             wr_n_s,
  input hs_state_t        state,
  input logic [CTL_W-1:0] ctl
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (ctl == CODE_IDLE && state == ST_IDLE)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rd_n_s && wr_n_s) |=> (state == ST_IDLE)); // R2

  AST_IDLE_TO_PRE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !(rd_n_s && wr_n_s)) |=> (state == ST_PRE)); // R3

  AST_PRE_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE) |=> (state == ST_ADDR && ctl == CODE_ADDR)); // R4

  AST_ADDR_TO_RD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && !rd_n_s && wr_n_s) |=> (state == ST_RD)); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && !rd_n_s && wr_n_s) |=> (state == ST_RD && ctl == CODE_RD)); // R6

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR && rd_n_s && !wr_n_s) |=> (state == ST_WR && ctl == CODE_WR)); // R7

  AST_ACTIVE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RD || state == ST_WR) && rd_n_s && wr_n_s) |=> (state == ST_IDLE)); // R8

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    (ctl == CODE_IDLE || ctl == CODE_ADDR || ctl == CODE_RD || ctl == CODE_WR)); // R10
endmodule

bind isa_strobe_fsm isa_strobe_fsm_chk u_chk (
  .clk(clk), .rst(rst), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
  .state(state_q), .ctl(ctl_q)
);

// File: tb/isa_strobe_fsm_tb.sv
module isa_strobe_fsm_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ior_n = 1'b1;
  logic iow_n = 1'b1;
  logic dir_o, agate_o, dgate_o, drive_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  isa_strobe_fsm u_dut (
    .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n),
    .dir_o(dir_o), .agate_o(agate_o), .dgate_o(dgate_o), .drive_o(drive_o)
  );

  // Reference model built from the requirements; states: 0 idle, 1 settle,
  // 2 address, 3 read, 4 write.
  logic [3:0]  exp_q[$];
  string       tag_q[$];
  logic        mr0 = 1'b1, mr1 = 1'b1, mw0 = 1'b1, mw1 = 1'b1;
  int          mst = 0;

  function automatic logic [3:0] code_for(int s);
    case (s)
      1, 2:    return 4'b0101;
      3:       return 4'b1001;
      4:       return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk) begin
    int    nst;
    string tg;
    if (rst) begin
      mr0 = 1'b1; mr1 = 1'b1; mw0 = 1'b1; mw1 = 1'b1;
      mst = 0;
      tg  = "R1";
    end else begin
      case (mst)
        0: begin nst = (mr1 && mw1) ? 0 : 1; tg = (nst == 0) ? "R2" : "R3/R9"; end
        1: begin nst = 2; tg = "R4"; end
        2: begin
             if (!mr1 && mw1)      nst = 3;
             else if (mr1 && !mw1) nst = 4;
             else                  nst = 0;
             tg = "R5";
           end
        3: begin nst = (!mr1 && mw1) ? 3 : 0; tg = (nst == 3) ? "R6" : "R8"; end
        4: begin nst = (mr1 && !mw1) ? 4 : 0; tg = (nst == 4) ? "R7" : "R8"; end
        default: begin nst = 0; tg = "R8"; end
      endcase
      mr1 = mr0; mw1 = mw0;
      mr0 = ior_n; mw0 = iow_n;
      mst = nst;
    end
    exp_q.push_back(code_for(mst));
    tag_q.push_back(tg);
  end

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    logic [3:0] act, exp;
    string      tg;
    if (exp_q.size() > 0 && !done) begin
      exp = exp_q.pop_front();
      tg  = tag_q.pop_front();
      act = {dir_o, agate_o, dgate_o, drive_o};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s: control code actual %b expected %b at %0t", tg, act, exp, $time);
      end
      checks++;  // R10: legal code only
      if (!(act == 4'b0000 || act == 4'b0101 || act == 4'b1001 || act == 4'b0011)) begin
        errors++;
        $display("FAIL R10: illegal code actual %b expected one of 0000/0101/1001/0011", act);
      end
    end
  end

  task automatic drive(input logic r, input logic w, input int n);
    @(negedge clk);
    ior_n = r; iow_n = w;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(1, 1, 5);   // R2 idle hold
    drive(0, 1, 8);   // R3 R4 R5 R6 read access
    drive(1, 1, 6);   // R8 release
    drive(1, 0, 8);   // R7 write access
    drive(1, 1, 6);   // R8 release
    drive(0, 0, 7);   // R5 both low at address -> idle, then re-enter
    drive(1, 1, 6);
    drive(0, 1, 1);   // one-clock pulse: settle/address then idle (R5, R9)
    drive(1, 1, 8);
    drive(1, 0, 6);   // write then both low: R8
    drive(0, 0, 2);
    drive(1, 1, 8);
    drive(0, 1, 6);   // read then switch to write only: R8
    drive(1, 0, 2);
    drive(1, 1, 8);
    drive(0, 1, 5);   // reset mid-access: R1
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(1, 1, 6);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule